// File: doc/BRIEF.md
# Multi-Mode Operand Address Unit

This unit turns an operand specifier into the value an execution stage needs. A request carries a 4-bit mode code, a base register value, an index register value, a constant (displacement or absolute address) and a 2-bit element-size code. Most modes are resolved with a single registered add. The result, a memory address, an immediate operand or a register operand, appears one cycle after the request is accepted. The base-register modifying modes also return a writeback value with an enable that lasts for one cycle.

The memory-indirect mode needs a pointer fetch. The unit raises a read request at the base address and lowers `req_ready` until the read completes. The fetched word is returned as the final address one cycle after the read is acknowledged. Mode codes outside the defined set complete in one cycle with an error flag and have no other effect.

Top module: `eff_addr_gen`

## Requirements
- R1: During and directly after reset, `res_valid`, `res_err`, `wb_en` and `mem_req` are 0 and `req_ready` is 1.
- R2: Mode 0 (register) returns `res_kind`=2 with `res_value` equal to the base value one cycle after acceptance. It issues no memory read and no writeback.
- R3: Mode 1 (immediate) returns `res_kind`=1 with `res_value` equal to the constant.
- R4: Mode 2 (displacement) returns constant+base. Mode 3 (deferred) returns the base alone. Both use `res_kind`=0.
- R5: Mode 4 (indexed) returns base+index. Mode 5 (absolute) returns the constant as the address.
- R6: Mode 9 (scaled) returns constant+base+index·d. The step d is 1, 2, 4 or 8 for size codes 0, 1, 2 and 3.
- R7: Mode 7 (post-increment) returns the base as the address. In the same cycle it asserts `wb_en` with `wb_value`=base+d.
- R8: Mode 8 (pre-decrement) returns base−d. In the same cycle it asserts `wb_en` with `wb_value`=base−d.
- R9: Mode 6 (memory-indirect) asserts `mem_req` with `mem_addr`=base from the cycle after acceptance. `mem_req` and `mem_addr` are held until `mem_ack` is high. `req_ready` stays low meanwhile, and requests offered then are ignored. The cycle after the ack, the unit returns `res_kind`=0 with `res_value` equal to the `mem_rdata` that came with the ack.
- R10: Mode codes 10 to 15 complete in one cycle with `res_valid` and `res_err` set, `res_value`=0, no writeback and no memory read.
- R11: `wb_en` is high only together with `res_valid` for modes 7 and 8.
- R12: All sums and differences wrap modulo 2^AW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Unit can accept a request |
| req_mode | input | 4 | Addressing mode code |
| req_base | input | AW | Base register value |
| req_index | input | AW | Index register value |
| req_const | input | AW | Displacement, absolute address or immediate |
| req_size | input | 2 | Element size code, d = 1<<code |
| res_valid | output | 1 | Result valid for one cycle |
| res_kind | output | 2 | 0 address, 1 immediate, 2 register |
| res_value | output | AW | Address or operand |
| res_err | output | 1 | Illegal mode code |
| wb_en | output | 1 | Base register writeback enable |
| wb_value | output | AW | Base register writeback value |
| mem_req | output | 1 | Pointer read request |
| mem_addr | output | AW | Pointer read address |
| mem_ack | input | 1 | Pointer read acknowledge with data |
| mem_rdata | input | AW | Pointer read data |

## Verification
The hardest case to reach is a request that arrives while a pointer read is outstanding. The read must not complete before the next request is offered, and that request must leave no trace. The bench's memory responder delays its acknowledge by a programmable number of cycles. A directed phase offers requests in every cycle of such a wait. A long random phase then holds `req_valid` high most of the time and mixes in all sixteen mode codes, so indirect fetches with varying latencies collide with queued requests and with back-to-back single-cycle modes.

// File: rtl/eag_pkg.sv
package eag_pkg;
   localparam logic [3:0] MD_REG   = 4'd0;
   localparam logic [3:0] MD_IMM   = 4'd1;
   localparam logic [3:0] MD_DISP  = 4'd2;
   localparam logic [3:0] MD_DEFER = 4'd3;
   localparam logic [3:0] MD_INDEX = 4'd4;
   localparam logic [3:0] MD_ABS   = 4'd5;
   localparam logic [3:0] MD_MIND  = 4'd6;
   localparam logic [3:0] MD_AINC  = 4'd7;
   localparam logic [3:0] MD_ADEC  = 4'd8;
   localparam logic [3:0] MD_SCALE = 4'd9;

   localparam logic [1:0] KIND_ADDR = 2'd0;
   localparam logic [1:0] KIND_IMM  = 2'd1;
   localparam logic [1:0] KIND_REG  = 2'd2;

   typedef enum logic {PS_IDLE, PS_WAIT} ptr_state_e;
endpackage

// File: rtl/eag_scaler.sv
module eag_scaler #(
   parameter int AW   = 32,
   parameter int IMPL = 0
) (
   input  logic [AW-1:0] val,
   input  logic [1:0]    sz,
   output logic [AW-1:0] scaled
);
   initial begin
      assert (AW >= 4) else $error("eag_scaler: AW must be at least 4");
      assert (IMPL == 0 || IMPL == 1) else $error("eag_scaler: IMPL must be 0 or 1");
   end

   generate
      if (IMPL == 0) begin : g_shift
         assign scaled = val << sz;
      end else begin : g_mux
         always_comb begin
            case (sz)
               2'd0:    scaled = val;
               2'd1:    scaled = {val[AW-2:0], 1'b0};
               2'd2:    scaled = {val[AW-3:0], 2'b00};
               default: scaled = {val[AW-4:0], 3'b000};
            endcase
         end
      end
   endgenerate
endmodule

// File: rtl/eag_calc.sv
module eag_calc
   import eag_pkg::*;
#(
   parameter int AW         = 32,
   parameter int SCALE_IMPL = 0
) (
   input  logic [3:0]    mode,
   input  logic [AW-1:0] base,
   input  logic [AW-1:0] index,
   input  logic [AW-1:0] kval,
   input  logic [1:0]    sz,
   output logic [AW-1:0] value,
   output logic [1:0]    kind,
   output logic          err,
   output logic          wb_en,
   output logic [AW-1:0] wb_value,
   output logic          indirect
);
   localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

   logic [AW-1:0] step;
   logic [AW-1:0] idx_scaled;
   logic [AW-1:0] base_dec;

   assign step     = ONE << sz;
   assign base_dec = base - step;

   eag_scaler #(.AW(AW), .IMPL(SCALE_IMPL)) u_scaler (
      .val    (index),
      .sz     (sz),
      .scaled (idx_scaled)
   );

   always_comb begin
      value    = '0;
      kind     = KIND_ADDR;
      err      = 1'b0;
      wb_en    = 1'b0;
      wb_value = '0;
      indirect = 1'b0;
      case (mode)
         MD_REG:   begin value = base; kind = KIND_REG; end
         MD_IMM:   begin value = kval; kind = KIND_IMM; end
         MD_DISP:  value = kval + base;
         MD_DEFER: value = base;
         MD_INDEX: value = base + index;
         MD_ABS:   value = kval;
         MD_MIND:  begin value = base; indirect = 1'b1; end
         MD_AINC:  begin value = base; wb_en = 1'b1; wb_value = base + step; end
         MD_ADEC:  begin value = base_dec; wb_en = 1'b1; wb_value = base_dec; end
         MD_SCALE: value = kval + base + idx_scaled;
         default:  err = 1'b1;
      endcase
   end
endmodule

// File: rtl/eag_ptr_fsm.sv
module eag_ptr_fsm
   import eag_pkg::*;
#(
   parameter int AW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [AW-1:0] ptr_addr,
   input  logic          mem_ack,
   output logic          busy,
   output logic          mem_req,
   output logic [AW-1:0] mem_addr,
   output logic          done
);
   ptr_state_e    state_q;
   logic [AW-1:0] addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= PS_IDLE;
         addr_q  <= '0;
      end else begin
         case (state_q)
            PS_IDLE: if (start) begin
               state_q <= PS_WAIT;
               addr_q  <= ptr_addr;
            end
            default: if (mem_ack) state_q <= PS_IDLE;
         endcase
      end
   end

   assign busy     = (state_q == PS_WAIT);
   assign mem_req  = busy;
   assign mem_addr = addr_q;
   assign done     = busy && mem_ack;

   // R9
   ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

   // R9
   ptr_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> (mem_req && mem_addr == $past(ptr_addr)));
endmodule

// File: rtl/eff_addr_gen.sv
module eff_addr_gen
   import eag_pkg::*;
#(
   parameter int AW         = 32,
   parameter int SCALE_IMPL = 0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   output logic          req_ready,
   input  logic [3:0]    req_mode,
   input  logic [AW-1:0] req_base,
   input  logic [AW-1:0] req_index,
   input  logic [AW-1:0] req_const,
   input  logic [1:0]    req_size,
   output logic          res_valid,
   output logic [1:0]    res_kind,
   output logic [AW-1:0] res_value,
   output logic          res_err,
   output logic          wb_en,
   output logic [AW-1:0] wb_value,
   output logic          mem_req,
   output logic [AW-1:0] mem_addr,
   input  logic          mem_ack,
   input  logic [AW-1:0] mem_rdata
);
   localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

   initial begin
      assert (AW >= 8) else $error("eff_addr_gen: AW must be at least 8");
   end

   logic          accept;
   logic          busy;
   logic          ptr_done;
   logic [AW-1:0] c_value;
   logic [1:0]    c_kind;
   logic          c_err;
   logic          c_wb_en;
   logic [AW-1:0] c_wb_value;
   logic          c_indirect;

   assign req_ready = !busy;
   assign accept    = req_valid && req_ready;

   eag_calc #(.AW(AW), .SCALE_IMPL(SCALE_IMPL)) u_calc (
      .mode     (req_mode),
      .base     (req_base),
      .index    (req_index),
      .kval     (req_const),
      .sz       (req_size),
      .value    (c_value),
      .kind     (c_kind),
      .err      (c_err),
      .wb_en    (c_wb_en),
      .wb_value (c_wb_value),
      .indirect (c_indirect)
   );

   eag_ptr_fsm #(.AW(AW)) u_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (accept && c_indirect),
      .ptr_addr (req_base),
      .mem_ack  (mem_ack),
      .busy     (busy),
      .mem_req  (mem_req),
      .mem_addr (mem_addr),
      .done     (ptr_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         res_kind  <= KIND_ADDR;
         res_value <= '0;
         res_err   <= 1'b0;
         wb_en     <= 1'b0;
         wb_value  <= '0;
      end else begin
         res_valid <= ptr_done || (accept && !c_indirect);
         res_err   <= accept && c_err;
         wb_en     <= accept && c_wb_en;
         if (ptr_done) begin
            res_kind  <= KIND_ADDR;
            res_value <= mem_rdata;
         end else if (accept && !c_indirect) begin
            res_kind  <= c_kind;
            res_value <= c_value;
            wb_value  <= c_wb_value;
         end
      end
   end

   // R11
   wb_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en |-> (res_valid && !res_err));

   // R10
   err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_err |-> (res_valid && !wb_en && res_value == '0));

   // R9
   ptr_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !req_ready);

   // R9
   ptr_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_ack) |=> (res_valid && res_kind == KIND_ADDR && res_value == $past(mem_rdata)));

   // R7
   post_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && req_mode == MD_AINC) |=> (wb_en && wb_value - res_value == (ONE << $past(req_size))));

   // R8
   pre_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && req_mode == MD_ADEC) |=> (wb_en && wb_value == res_value));
endmodule

// File: tb/eff_addr_gen_tb.sv
`timescale 1ns/1ps
module eff_addr_gen_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [3:0]  req_mode = 4'd0;
   logic [31:0] req_base = '0, req_index = '0, req_const = '0;
   logic [1:0]  req_size = 2'd0;
   logic        res_valid, res_err, wb_en, mem_req;
   logic [1:0]  res_kind;
   logic [31:0] res_value, wb_value, mem_addr;
   logic        mem_ack = 1'b0;
   logic [31:0] mem_rdata = '0;

   int checks = 0;
   int errors = 0;
   int lat = 0;
   bit done = 0;

   always #2 clk = ~clk;

   eff_addr_gen u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_mode(req_mode), .req_base(req_base), .req_index(req_index),
      .req_const(req_const), .req_size(req_size), .res_valid(res_valid),
      .res_kind(res_kind), .res_value(res_value), .res_err(res_err),
      .wb_en(wb_en), .wb_value(wb_value), .mem_req(mem_req), .mem_addr(mem_addr),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata)
   );

   // reference model state
   logic        e_valid = 0, e_err = 0, e_wb = 0, m_busy = 0;
   logic [1:0]  e_kind = 0;
   logic [31:0] e_value = 0, e_wbv = 0, m_addr = 0;
   string       e_tag = "R1";

   function automatic string tag_of(input logic [3:0] m);
      case (m)
         4'd0: return "R2";
         4'd1: return "R3";
         4'd2, 4'd3: return "R4";
         4'd4, 4'd5: return "R5";
         4'd6: return "R9";
         4'd7: return "R7";
         4'd8: return "R8";
         4'd9: return "R6";
         default: return "R10";
      endcase
   endfunction

   always @(posedge clk) begin
      logic [31:0] d;
      d = 32'd1 << req_size;
      e_valid <= 1'b0;
      e_err   <= 1'b0;
      e_wb    <= 1'b0;
      if (!rst_n) begin
         m_busy <= 1'b0;
         e_tag  <= "R1";
      end else if (m_busy) begin
         if (mem_ack) begin
            m_busy  <= 1'b0;
            e_valid <= 1'b1;
            e_kind  <= 2'd0;
            e_value <= mem_rdata;
            e_tag   <= "R9";
         end
      end else if (req_valid) begin
         e_tag <= tag_of(req_mode);
         if (req_mode == 4'd6) begin
            m_busy <= 1'b1;
            m_addr <= req_base;
         end else begin
            e_valid <= 1'b1;
            e_kind  <= 2'd0;
            case (req_mode)
               4'd0: begin e_kind <= 2'd2; e_value <= req_base; end
               4'd1: begin e_kind <= 2'd1; e_value <= req_const; end
               4'd2: e_value <= req_const + req_base;
               4'd3: e_value <= req_base;
               4'd4: e_value <= req_base + req_index;
               4'd5: e_value <= req_const;
               4'd7: begin e_value <= req_base; e_wb <= 1'b1; e_wbv <= req_base + d; end
               4'd8: begin e_value <= req_base - d; e_wb <= 1'b1; e_wbv <= req_base - d; end
               4'd9: e_value <= req_const + req_base + req_index * d;
               default: begin e_err <= 1'b1; e_value <= 32'd0; end
            endcase
         end
      end
   end

   task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
      end
   endtask

   // compare every cycle once reset is released
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R9", "req_ready", {31'd0, req_ready}, {31'd0, !m_busy});
         chk("R9", "mem_req", {31'd0, mem_req}, {31'd0, m_busy});
         if (m_busy) chk("R9", "mem_addr", mem_addr, m_addr);
         chk(e_tag, "res_valid", {31'd0, res_valid}, {31'd0, e_valid});
         chk("R11", "wb_en", {31'd0, wb_en}, {31'd0, e_wb});
         if (e_valid) begin
            chk(e_tag, "res_value", res_value, e_value);
            chk(e_tag, "res_kind", {30'd0, res_kind}, {30'd0, e_kind});
            chk(e_tag, "res_err", {31'd0, res_err}, {31'd0, e_err});
         end
         if (e_wb) chk(e_tag, "wb_value", wb_value, e_wbv);
      end
   end

   // memory responder with programmable latency
   int wcnt = 0;
   always @(negedge clk) begin
      if (mem_req && !mem_ack) begin
         if (wcnt >= lat) begin
            mem_ack   <= 1'b1;
            mem_rdata <= {mem_addr[15:0], mem_addr[31:16]} ^ 32'h5A5A_3C3C;
         end else begin
            wcnt = wcnt + 1;
         end
      end else begin
         mem_ack <= 1'b0;
         wcnt = 0;
      end
   end

   task automatic drive(input logic v, input logic [3:0] m, input logic [31:0] b,
                        input logic [31:0] x, input logic [31:0] k, input logic [1:0] s);
      @(negedge clk);
      req_valid = v; req_mode = m; req_base = b; req_index = x; req_const = k; req_size = s;
   endtask

   task automatic one(input logic [3:0] m, input logic [31:0] b,
                      input logic [31:0] x, input logic [31:0] k, input logic [1:0] s);
      drive(1'b1, m, b, x, k, s);
      drive(1'b0, 4'd0, 32'd0, 32'd0, 32'd0, 2'd0);
      while (!req_ready) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1", "res_valid", {31'd0, res_valid}, 32'd0);
      chk("R1", "wb_en", {31'd0, wb_en}, 32'd0);
      chk("R1", "mem_req", {31'd0, mem_req}, 32'd0);
      chk("R1", "req_ready", {31'd0, req_ready}, 32'd1);
      chk("R1", "res_err", {31'd0, res_err}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      one(4'd0, 32'h1234_5678, 32'h1, 32'h2, 2'd0);        // R2
      one(4'd1, 32'h1, 32'h2, 32'hCAFE_F00D, 2'd1);        // R3
      one(4'd2, 32'h0000_1000, 32'h0, 32'h0000_0040, 2'd0); // R4
      one(4'd3, 32'h0000_2000, 32'h5, 32'h7, 2'd0);        // R4
      one(4'd4, 32'h0000_3000, 32'h0000_0123, 32'h9, 2'd0); // R5
      one(4'd5, 32'h5, 32'h6, 32'h8000_0000, 2'd0);        // R5
      for (int s = 0; s < 4; s++) begin
         one(4'd9, 32'h0000_4000, 32'h0000_0011, 32'h10, 2'(s)); // R6
         one(4'd7, 32'h0000_5000, 32'h0, 32'h0, 2'(s));          // R7
         one(4'd8, 32'h0000_6000, 32'h0, 32'h0, 2'(s));          // R8
      end
      // R12 wraparound
      one(4'd7, 32'hFFFF_FFFC, 32'h0, 32'h0, 2'd3);
      one(4'd8, 32'h0000_0002, 32'h0, 32'h0, 2'd3);
      one(4'd9, 32'hFFFF_FFF0, 32'h8000_0001, 32'h20, 2'd2);
      one(4'd2, 32'hFFFF_FF00, 32'h0, 32'h0000_0200, 2'd0);
      // R10 illegal codes
      for (int m = 10; m < 16; m++) one(4'(m), 32'h77, 32'h88, 32'h99, 2'd1);
      // R9 indirect, several latencies, with requests offered during the wait
      for (int l = 0; l < 4; l++) begin
         lat = l;
         drive(1'b1, 4'd6, 32'hABCD_0000 + 32'(l), 32'h0, 32'h0, 2'd0);
         for (int c = 0; c < l + 2; c++) drive(1'b1, 4'd7, 32'h100 * 32'(c + 1), 32'h0, 32'h0, 2'd2);
         drive(1'b0, 4'd0, 32'd0, 32'd0, 32'd0, 2'd0);
         repeat (3) @(negedge clk);
      end
      // back-to-back and random traffic
      for (int i = 0; i < 3000; i++) begin
         lat = int'($urandom_range(0, 4));
         drive(($urandom_range(0, 7) != 0), 4'($urandom_range(0, 15)), $urandom, $urandom,
               $urandom, 2'($urandom_range(0, 3)));
      end
      drive(1'b0, 4'd0, 32'd0, 32'd0, 32'd0, 2'd0);
      repeat (10) @(negedge clk);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      done = 1;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule